// File: doc/BRIEF.md
# Cyclic Sync Pulse Generator

This block drives two synchronisation pulse outputs from a free-running 64-bit nanosecond system time. Software first supplies four settings:

- a start time;
- a repeat interval for the first output;
- a delay from each first-output pulse to the matching second-output pulse;
- a pulse width in 10 ns units.

It then writes the activation bits. Each output has its own scheduler. The scheduler compares the next-event time it holds against system time. When the event fires, the scheduler raises the output and moves the stored time forward by exactly one interval. Moving forward from the stored time, and not from the moment of firing, keeps the phase free of drift.

A zero interval makes each output fire exactly once. A zero pulse width selects acknowledge mode. In that mode an output stays high until its own status-read strobe arrives. The block exposes the next-pulse time of each output. It also exposes one flag per output that stays set until that output's first pulse has occurred.

Each output scheduler is a state machine with five states:

- CH_IDLE: unit or output disabled.
- CH_FIRST_WAIT: armed, first pulse pending.
- CH_PULSE: output high.
- CH_NEXT_WAIT: waiting for a later pulse.
- CH_DONE: single shot finished.

The transitions are:

- arm (CH_IDLE to CH_FIRST_WAIT): the output becomes enabled.
- fire (either wait state to CH_PULSE): system time reaches the schedule.
- release (CH_PULSE to CH_NEXT_WAIT, or to CH_DONE when the interval is zero): the width elapses, or the acknowledge strobe arrives in acknowledge mode.
- drop (any state to CH_IDLE): the enable is removed.

Top module: `sync_pulse_gen`

## Requirements
- R1: After reset both outputs and both pending flags are 0, and both next-time outputs read 0.
- R2: The activation word has bit 0 as the unit enable, bit 1 as the first-output enable and bit 2 as the second-output enable. A write with bit 0 set is ignored unless a start time has been written since reset.
- R3: On activation, next0_time equals the start time and next1_time equals the start time plus delay1. The pending flag of each enabled output stays 1 until that output first fires.
- R4: An output rises on the first clock edge at which system time is greater than or equal to its scheduled time. Its next scheduled time becomes the previous scheduled time plus cycle0.
- R5: The second output fires at each first-output time plus delay1, with the same interval as the first output.
- R6: With a nonzero width, an output falls on the first edge at which system time reaches its scheduled time plus width times 10 ns.
- R7: With cycle0 equal to 0, each enabled output produces exactly one pulse.
- R8: With a width of 0, an output stays high until its own acknowledge strobe. The other output's strobe has no effect on it.
- R9: Clearing the unit enable drops both outputs and both pending flags within two clock edges of the write.
- R10: An output whose own enable bit is 0 never pulses, and its pending flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | 64 | Free-running system time in ns |
| start_time | input | 64 | Start time, captured on start_wr |
| start_wr | input | 1 | Strobe: capture start_time |
| cycle0 | input | 32 | First-output interval in ns (0 = single shot) |
| delay1 | input | 32 | Delay from first-output pulse to second-output pulse in ns |
| pulse_width | input | 16 | Pulse width in 10 ns units (0 = acknowledge mode) |
| act_wr | input | 1 | Strobe: write activation bits |
| act_data | input | 3 | Activation bits: unit, first output, second output |
| ack0_rd | input | 1 | Status-read strobe for the first output |
| ack1_rd | input | 1 | Status-read strobe for the second output |
| sync0 | output | 1 | First pulse output |
| sync1 | output | 1 | Second pulse output |
| pending0 | output | 1 | First pulse of sync0 still pending |
| pending1 | output | 1 | First pulse of sync1 still pending |
| next0_time | output | 64 | Scheduled time of the next sync0 pulse |
| next1_time | output | 64 | Scheduled time of the next sync1 pulse |

## Verification
System time advances 4 ns per clock, and every start, interval and width is a multiple of 4. As a result, each rise and fall lands on an exact system-time value that the bench predicts.

A repeating pattern with a nonzero delay tells apart three faults:

- phase-preserving stepping versus stepping from the moment of firing;
- a correct versus a missing offset on the second output;
- the wrong unit applied to the width.

A single-shot pattern separates exactly-once firing from repetition. An acknowledge-mode pattern with strobes sent one at a time exposes cross-coupled acknowledges. Two further patterns probe gating on the activation bits: activation before any start write, and a write that enables only the first output. A disable issued during a pulse checks the drop path.

// File: rtl/sync_pulse_pkg.sv
package sync_pulse_pkg;
    localparam int TIME_W  = 64;
    localparam int CYCLE_W = 32;
    localparam int WIDTH_W = 16;
    localparam int UNIT_NS = 10;
    localparam int N_OUT   = 2;

    typedef enum logic [2:0] {
        CH_IDLE,
        CH_FIRST_WAIT,
        CH_PULSE,
        CH_NEXT_WAIT,
        CH_DONE
    } ch_state_e;
endpackage

// File: rtl/sync_pulse_chan.sv
module sync_pulse_chan
    import sync_pulse_pkg::*;
#(
    parameter int T_W = TIME_W,
    parameter int C_W = CYCLE_W,
    parameter int W_W = WIDTH_W,
    parameter int U_NS = UNIT_NS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic [T_W-1:0] sys_time_i,
    input  logic [T_W-1:0] start_i,
    input  logic [C_W-1:0] offset_i,
    input  logic [C_W-1:0] cycle_i,
    input  logic [W_W-1:0] width_i,
    input  logic           ack_i,
    output logic           pulse_o,
    output logic           pending_o,
    output logic [T_W-1:0] next_o
);
    ch_state_e      state_q, state_d;
    logic [T_W-1:0] sched_q, sched_d;
    logic [T_W-1:0] end_q, end_d;
    logic [T_W-1:0] width_ns;
    logic           due, over, ack_mode, release_now;

    assign width_ns    = T_W'(width_i) * T_W'(U_NS);
    assign due         = sys_time_i >= sched_q;
    assign over        = sys_time_i >= end_q;
    assign ack_mode    = (width_i == '0);
    assign release_now = ack_mode ? ack_i : over;

    always_comb begin
        state_d = state_q;
        sched_d = sched_q;
        end_d   = end_q;
        if (!en_i) begin
            state_d = CH_IDLE;
        end else begin
            unique case (state_q)
                CH_IDLE: begin
                    state_d = CH_FIRST_WAIT;
                    sched_d = start_i + T_W'(offset_i);
                end
                CH_FIRST_WAIT, CH_NEXT_WAIT: begin
                    if (due) begin
                        state_d = CH_PULSE;
                        end_d   = sched_q + width_ns;
                        if (cycle_i != '0)
                            sched_d = sched_q + T_W'(cycle_i);
                    end
                end
                CH_PULSE: begin
                    if (release_now)
                        state_d = (cycle_i == '0) ? CH_DONE : CH_NEXT_WAIT;
                end
                CH_DONE: state_d = CH_DONE;
                default: state_d = CH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            sched_q <= '0;
            end_q   <= '0;
        end else begin
            state_q <= state_d;
            sched_q <= sched_d;
            end_q   <= end_d;
        end
    end

    always_comb begin
        pulse_o   = (state_q == CH_PULSE);
        pending_o = (state_q == CH_FIRST_WAIT);
        next_o    = sched_q;
    end

    // R4: a rise only happens once the schedule is due
    assert_fire_due_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> ($past(sys_time_i) >= $past(sched_q)));

    // R4: schedule advances by exactly one interval from the old schedule
    assert_step_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pulse_o) && ($past(cycle_i) != '0)) |->
        (sched_q == $past(sched_q) + T_W'($past(cycle_i))));

    // R3: pending only clears by firing while enabled
    assert_pending_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pending_o) && $past(en_i)) |-> pulse_o);

    // R8: acknowledge mode holds the pulse until the strobe
    assert_ack_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && ack_mode && !ack_i && en_i) |=> pulse_o);

    // R9: losing the enable drops pulse and pending
    assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!pulse_o && !pending_o));
endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
    import sync_pulse_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIME_W-1:0]  sys_time,
    input  logic [TIME_W-1:0]  start_time,
    input  logic               start_wr,
    input  logic [CYCLE_W-1:0] cycle0,
    input  logic [CYCLE_W-1:0] delay1,
    input  logic [WIDTH_W-1:0] pulse_width,
    input  logic               act_wr,
    input  logic [N_OUT:0]     act_data,
    input  logic               ack0_rd,
    input  logic               ack1_rd,
    output logic               sync0,
    output logic               sync1,
    output logic               pending0,
    output logic               pending1,
    output logic [TIME_W-1:0]  next0_time,
    output logic [TIME_W-1:0]  next1_time
);
    logic [TIME_W-1:0]  start_q;
    logic               start_seen_q;
    logic [N_OUT:0]     act_q;
    logic [CYCLE_W-1:0] offs  [N_OUT];
    logic [N_OUT-1:0]   acks, pulses, pends;
    logic [TIME_W-1:0]  nexts [N_OUT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q      <= '0;
            start_seen_q <= 1'b0;
            act_q        <= '0;
        end else begin
            if (start_wr) begin
                start_q      <= start_time;
                start_seen_q <= 1'b1;
            end
            if (act_wr && (!act_data[0] || start_seen_q))
                act_q <= act_data;
        end
    end

    assign offs[0] = '0;
    assign offs[1] = delay1;
    assign acks    = {ack1_rd, ack0_rd};

    for (genvar i = 0; i < N_OUT; i++) begin : g_chan
        sync_pulse_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (act_q[0] & act_q[i+1]),
            .sys_time_i (sys_time),
            .start_i    (start_q),
            .offset_i   (offs[i]),
            .cycle_i    (cycle0),
            .width_i    (pulse_width),
            .ack_i      (acks[i]),
            .pulse_o    (pulses[i]),
            .pending_o  (pends[i]),
            .next_o     (nexts[i])
        );
    end

    assign sync0      = pulses[0];
    assign sync1      = pulses[1];
    assign pending0   = pends[0];
    assign pending1   = pends[1];
    assign next0_time = nexts[0];
    assign next1_time = nexts[1];

    // R2: the unit cannot be enabled before a start time exists
    assert_unit_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act_q[0] |-> start_seen_q);
endmodule

// File: tb/sync_pulse_gen_test.sv
module sync_pulse_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_time = 64'd0;
    logic [63:0] start_time = 64'd0;
    logic        start_wr = 1'b0;
    logic [31:0] cycle0 = 32'd0;
    logic [31:0] delay1 = 32'd0;
    logic [15:0] pulse_width = 16'd0;
    logic        act_wr = 1'b0;
    logic [2:0]  act_data = 3'd0;
    logic        ack0_rd = 1'b0, ack1_rd = 1'b0;
    logic        sync0, sync1, pending0, pending1;
    logic [63:0] next0_time, next1_time;

    int checks = 0, failures = 0;
    bit done = 0;
    int n0 = 0, n1 = 0, f0n = 0;
    logic [63:0] r0 [16];
    logic [63:0] r1 [16];
    logic [63:0] fl0 [16];

    sync_pulse_gen uut (.*);

    always #2 clk = ~clk;

    always @(negedge clk) if (rst_n) sys_time <= sys_time + 64'd4;

    always @(posedge sync0) begin r0[n0 % 16] = sys_time; n0++; end
    always @(posedge sync1) begin r1[n1 % 16] = sys_time; n1++; end
    always @(negedge sync0) begin fl0[f0n % 16] = sys_time; f0n++; end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_act(input logic [2:0] bits);
        act_data = bits; act_wr = 1'b1; cyc(1); act_wr = 1'b0; cyc(2);
    endtask

    task automatic write_start(input logic [63:0] t);
        start_time = t; start_wr = 1'b1; cyc(1); start_wr = 1'b0;
    endtask

    task automatic wait_count0(input int target);
        for (int k = 0; k < 5000 && n0 < target; k++) cyc(1);
    endtask

    task automatic t_reset;
        chk(sync0 == 0 && sync1 == 0, "R1 outputs", {62'd0, sync1, sync0}, 0);
        chk(pending0 == 0 && pending1 == 0, "R1 pending", {62'd0, pending1, pending0}, 0);
        chk(next0_time == 0, "R1 next0", next0_time, 0);
        chk(next1_time == 0, "R1 next1", next1_time, 0);
    endtask

    task automatic t_no_start;
        write_act(3'b111);
        cyc(25);
        chk(pending0 == 0 && pending1 == 0, "R2 pending", {62'd0, pending1, pending0}, 0);
        chk(n0 == 0 && n1 == 0, "R2 pulses", 64'(n0 + n1), 0);
    endtask

    task automatic t_periodic;
        logic [63:0] t0;
        int b0, b1;
        write_act(3'b000);
        cycle0 = 32'd1000; delay1 = 32'd300; pulse_width = 16'd20;
        t0 = sys_time + 64'd400;
        write_start(t0);
        b0 = n0; b1 = n1;
        write_act(3'b111);
        chk(pending0 == 1 && pending1 == 1, "R3 pending set", {62'd0, pending1, pending0}, 3);
        chk(next0_time == t0, "R3 next0", next0_time, t0);
        chk(next1_time == t0 + 300, "R3 next1", next1_time, t0 + 300);
        wait_count0(b0 + 1);
        cyc(1);
        chk(next0_time == t0 + 1000, "R4 next0 stepped", next0_time, t0 + 1000);
        chk(pending0 == 0 && pending1 == 1, "R3 pending per output", {62'd0, pending1, pending0}, 2);
        wait_count0(b0 + 3);
        cyc(2);
        chk(r0[b0 % 16] == t0, "R4 rise 1", r0[b0 % 16], t0);
        chk(r0[(b0 + 1) % 16] == t0 + 1000, "R4 rise 2", r0[(b0 + 1) % 16], t0 + 1000);
        chk(r0[(b0 + 2) % 16] == t0 + 2000, "R4 rise 3", r0[(b0 + 2) % 16], t0 + 2000);
        chk(r1[b1 % 16] == t0 + 300, "R5 sync1 rise 1", r1[b1 % 16], t0 + 300);
        chk(r1[(b1 + 1) % 16] == t0 + 1300, "R5 sync1 rise 2", r1[(b1 + 1) % 16], t0 + 1300);
        chk(fl0[b0 % 16] - r0[b0 % 16] == 200, "R6 width 1", fl0[b0 % 16] - r0[b0 % 16], 200);
        chk(fl0[(b0 + 1) % 16] - r0[(b0 + 1) % 16] == 200, "R6 width 2",
            fl0[(b0 + 1) % 16] - r0[(b0 + 1) % 16], 200);
    endtask

    task automatic t_disable;
        int b0, b1;
        for (int k = 0; k < 2000 && !sync0; k++) cyc(1);
        act_data = 3'b000; act_wr = 1'b1; cyc(1); act_wr = 1'b0; cyc(2);
        chk(sync0 == 0 && sync1 == 0, "R9 outputs dropped", {62'd0, sync1, sync0}, 0);
        chk(pending0 == 0 && pending1 == 0, "R9 pending dropped", {62'd0, pending1, pending0}, 0);
        b0 = n0; b1 = n1;
        cyc(500);
        chk(n0 == b0 && n1 == b1, "R9 stays quiet", 64'(n0 + n1 - b0 - b1), 0);
    endtask

    task automatic t_single;
        logic [63:0] t0;
        int b0, b1;
        cycle0 = 32'd0; delay1 = 32'd300; pulse_width = 16'd20;
        t0 = sys_time + 64'd200;
        write_start(t0);
        b0 = n0; b1 = n1;
        write_act(3'b111);
        cyc(1000);
        chk(n0 == b0 + 1, "R7 sync0 once", 64'(n0 - b0), 1);
        chk(n1 == b1 + 1, "R7 sync1 once", 64'(n1 - b1), 1);
        chk(r0[b0 % 16] == t0, "R7 sync0 time", r0[b0 % 16], t0);
        chk(r1[b1 % 16] == t0 + 300, "R7 sync1 time", r1[b1 % 16], t0 + 300);
        write_act(3'b000);
    endtask

    task automatic t_ack;
        cycle0 = 32'd0; delay1 = 32'd100; pulse_width = 16'd0;
        write_start(sys_time + 64'd200);
        write_act(3'b111);
        cyc(500);
        chk(sync0 == 1 && sync1 == 1, "R8 held high", {62'd0, sync1, sync0}, 3);
        ack1_rd = 1'b1; cyc(1); ack1_rd = 1'b0; cyc(1);
        chk(sync1 == 0, "R8 ack1 clears sync1", {63'd0, sync1}, 0);
        chk(sync0 == 1, "R8 ack1 leaves sync0", {63'd0, sync0}, 1);
        ack0_rd = 1'b1; cyc(1); ack0_rd = 1'b0; cyc(1);
        chk(sync0 == 0, "R8 ack0 clears sync0", {63'd0, sync0}, 0);
        write_act(3'b000);
    endtask

    task automatic t_one_output;
        int b0, b1;
        cycle0 = 32'd1000; delay1 = 32'd300; pulse_width = 16'd20;
        write_start(sys_time + 64'd200);
        b0 = n0; b1 = n1;
        write_act(3'b011);
        chk(pending1 == 0, "R10 pending1 stays 0", {63'd0, pending1}, 0);
        cyc(800);
        chk(n1 == b1, "R10 sync1 silent", 64'(n1 - b1), 0);
        chk(n0 >= b0 + 2, "R10 sync0 runs", 64'(n0 - b0), 2);
        write_act(3'b000);
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_no_start();
        t_periodic();
        t_disable();
        t_single();
        t_ack();
        t_one_output();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule